// File: doc/BRIEF.md
# Pipelined SPI Channel-Scanning Master

This block is the host side of a four-channel sensor serial port. Each access is a fixed 16-clock SPI frame. In every frame the master shifts out a 12-bit command that names the channel the target should convert next. In the same frame it shifts in the conversion result for the channel named one frame earlier. The master loops over the enabled channels in rising order. Because every result arrives one frame after its request, the master keeps one request outstanding at all times.

Each result is labelled with the two-bit address that the target puts into the returned word, not with a label taken from the master's own request log. That address is also compared against the request the master made one frame earlier. A mismatch, or a non-zero leading pair of bits, raises an error flag on that result. The system clock divided by `DIV_HALF` sets each half period of the serial clock. `QUIET_CYC` sets the minimum time between frames during which chip select stays high. With the defaults and a 200 MHz clock, SCLK runs at 20 MHz and the gap is at least 50 ns.

Top module: `spi_scan_master`

## Requirements
- R1: Every frame holds `spi_cs_n` low for exactly 16 falling edges of `spi_sclk`. Whenever `spi_cs_n` is high, `spi_sclk` is high.
- R2: Each of the following lasts exactly `DIV_HALF` clock cycles: every low phase and every high phase of `spi_sclk` inside a frame, the interval from the `spi_cs_n` fall to the first `spi_sclk` fall, and the interval from the last `spi_sclk` rise to the `spi_cs_n` rise.
- R3: `spi_mosi` changes only at rising `spi_sclk` edges, never during a low phase or at a falling edge. Stream bit 0 is sent first.
  - Bits 0..11 are 1, 0, 0, 0, A1, A0, 1, 1, 0, 0, 0, C. A1:A0 is the requested channel and C is `coding_sel` sampled at frame start.
  - Bits 12..15 are 0.
- R4: Channels are requested in rising numeric order among the set bits of `ch_mask`, wrapping from 3 to 0. The first request after a start goes to the lowest enabled channel.
- R5: The first frame after a start yields no result. Every later frame yields exactly one `res_valid` pulse, one cycle long, in the cycle `spi_cs_n` returns high. No pulse appears at any other time.
- R6: `res_tag` equals returned stream bits 2..3, and `res_data` equals returned bits 4..15, MSB first. Bits are sampled on `spi_miso` at each rising `spi_sclk` edge.
- R7: `res_err` is 1 exactly when returned bits 0..1 are not both zero, or when `res_tag` differs from the channel requested in the previous frame.
- R8: Between the end of one frame and the start of the next, `spi_cs_n` stays high for at least `QUIET_CYC` clock cycles.
- R9: No frame starts while `run` is low or `ch_mask` is zero. A frame already under way completes and still delivers its result.
- R10: Out of reset, `spi_cs_n`=1, `spi_sclk`=1, `spi_mosi`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scan enable; frames start only while high |
| ch_mask | input | 4 | One enable bit per channel |
| coding_sel | input | 1 | Output-coding bit placed in each command |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Command data to the target |
| spi_miso | input | 1 | Result data from the target |
| res_valid | output | 1 | One-cycle result strobe |
| res_tag | output | 2 | Channel address carried in the returned word |
| res_data | output | 12 | Returned conversion value |
| res_err | output | 1 | Protocol error on this result |

## Verification
A wrong channel pointer appears at once as a wrong address in the command bits of the next frame. A stale previous-request register appears one frame later, as an error flag that the returned tag does not justify. A slip in the half-period counter or the bit counter changes the measured edge spacing, or the number of falling edges, within the same frame. A broken priming flag appears in the cycle chip select rises, as a result strobe that is missing or that should not be there. The model target in the bench corrupts some replies at random, so the error logic is exercised on both true and false cases.

// File: rtl/ssm_pkg.sv
`timescale 1ns/1ps
package ssm_pkg;
  localparam int CH_AW     = 2;
  localparam int NUM_CH    = 1 << CH_AW;
  localparam int FRAME_LEN = 16;
  localparam int DATA_W    = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_LOW,
    ST_HIGH
  } ssm_state_e;

  // Sixteen-bit outgoing stream, first bit in the MSB.
  function automatic logic [FRAME_LEN-1:0] make_cmd(input logic [CH_AW-1:0] addr,
                                                    input logic coding);
    return {1'b1, 1'b0, 2'b00, addr, 2'b11, 2'b00, 1'b0, coding, 4'b0000};
  endfunction
endpackage

// File: rtl/ssm_half_timer.sv
`timescale 1ns/1ps
module ssm_half_timer #(
  parameter int DIV_HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = active && (cnt_q == CW'(DIV_HALF - 1));

  always_comb begin
    if (!active || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ssm_chan_pick.sv
`timescale 1ns/1ps
module ssm_chan_pick #(
  parameter int AW = 2,
  parameter int N  = 1 << AW
) (
  input  logic [AW-1:0] last,
  input  logic [N-1:0]  mask,
  output logic [AW-1:0] pick,
  output logic          any
);
  // First enabled channel after 'last', wrapping; nearest candidate wins.
  always_comb begin
    pick = last;
    for (int k = N; k >= 1; k--) begin
      if (mask[AW'(last + AW'(k))]) pick = AW'(last + AW'(k));
    end
  end

  assign any = |mask;
endmodule

// File: rtl/spi_scan_master.sv
`timescale 1ns/1ps
module spi_scan_master
  import ssm_pkg::*;
#(
  parameter int DIV_HALF  = 5,
  parameter int QUIET_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic              coding_sel,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              res_valid,
  output logic [CH_AW-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);
  localparam int BW = $clog2(FRAME_LEN + 1);
  localparam int GW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ssm_state_e           state_q, state_d;
  logic                 cs_n_q, cs_n_d, sclk_q, sclk_d;
  logic [FRAME_LEN-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [GW-1:0]        gap_q, gap_d;
  logic [CH_AW-1:0]     last_q, last_d, cur_q, cur_d, prev_q, prev_d;
  logic                 pvld_q, pvld_d;
  logic                 rv_q, rv_d, rerr_q, rerr_d;
  logic [CH_AW-1:0]     rtag_q, rtag_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic                 tmr_active, half_tick, any_ch;
  logic [CH_AW-1:0]     pick_ch;

  assign tmr_active = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);

  ssm_half_timer #(.DIV_HALF(DIV_HALF)) u_tmr (
    .clk   (clk),
    .rst_n (rst_ni),
    .active(tmr_active),
    .tick  (half_tick)
  );

  ssm_chan_pick #(.AW(CH_AW)) u_pick (
    .last(last_q),
    .mask(ch_mask),
    .pick(pick_ch),
    .any (any_ch)
  );

  always_comb begin
    state_d = state_q;  cs_n_d = cs_n_q;   sclk_d = sclk_q;
    tx_d    = tx_q;     rx_d   = rx_q;     bit_d  = bit_q;   gap_d = gap_q;
    last_d  = last_q;   cur_d  = cur_q;    prev_d = prev_q;  pvld_d = pvld_q;
    rv_d    = 1'b0;     rtag_d = rtag_q;   rdata_d = rdata_q; rerr_d = rerr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (run && any_ch) begin
          state_d = ST_SETUP;
          cs_n_d  = 1'b0;
          tx_d    = make_cmd(pick_ch, coding_sel);
          cur_d   = pick_ch;
          last_d  = pick_ch;
          bit_d   = '0;
        end else begin
          last_d = CH_AW'(NUM_CH - 1);
          pvld_d = 1'b0;
        end
      end
      ST_SETUP: begin
        if (half_tick) begin
          state_d = ST_LOW;
          sclk_d  = 1'b0;
        end
      end
      ST_LOW: begin
        if (half_tick) begin
          state_d = ST_HIGH;
          sclk_d  = 1'b1;
          rx_d    = {rx_q[FRAME_LEN-2:0], spi_miso};
          tx_d    = {tx_q[FRAME_LEN-2:0], 1'b0};
          bit_d   = bit_q + BW'(1);
        end
      end
      ST_HIGH: begin
        if (half_tick) begin
          if (bit_q == BW'(FRAME_LEN)) begin
            state_d = ST_GAP;
            cs_n_d  = 1'b1;
            gap_d   = '0;
            rv_d    = pvld_q;
            rtag_d  = rx_q[DATA_W+CH_AW-1:DATA_W];
            rdata_d = rx_q[DATA_W-1:0];
            rerr_d  = (rx_q[FRAME_LEN-1:DATA_W+CH_AW] != '0) ||
                      (rx_q[DATA_W+CH_AW-1:DATA_W] != prev_q);
            prev_d  = cur_q;
            pvld_d  = 1'b1;
          end else begin
            state_d = ST_LOW;
            sclk_d  = 1'b0;
          end
        end
      end
      ST_GAP: begin
        if (gap_q == GW'(QUIET_CYC - 1)) state_d = ST_IDLE;
        else                             gap_d   = gap_q + GW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  cs_n_q <= 1'b1;  sclk_q <= 1'b1;
      tx_q    <= '0;       rx_q   <= '0;    bit_q  <= '0;   gap_q <= '0;
      last_q  <= CH_AW'(NUM_CH - 1);        cur_q  <= '0;   prev_q <= '0;
      pvld_q  <= 1'b0;     rv_q   <= 1'b0;  rtag_q <= '0;   rdata_q <= '0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;  cs_n_q <= cs_n_d;  sclk_q <= sclk_d;
      tx_q    <= tx_d;     rx_q   <= rx_d;    bit_q  <= bit_d;  gap_q <= gap_d;
      last_q  <= last_d;   cur_q  <= cur_d;   prev_q <= prev_d;
      pvld_q  <= pvld_d;   rv_q   <= rv_d;    rtag_q <= rtag_d; rdata_q <= rdata_d;
      rerr_q  <= rerr_d;
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = tx_q[FRAME_LEN-1];
  assign res_valid = rv_q;
  assign res_tag   = rtag_q;
  assign res_data  = rdata_q;
  assign res_err   = rerr_q;
endmodule

// File: rtl/ssm_checker.sv
`timescale 1ns/1ps
module ssm_checker #(
  parameter int QUIET_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic res_valid
);
  logic [15:0] hi_cnt_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (spi_cs_n) hi_cnt_q <= (hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 16'd1;
      else          hi_cnt_q <= '0;
      if (!spi_cs_n) seen_q <= 1'b1;
    end
  end

  // R1
  cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R5
  result_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(spi_cs_n));

  // R3
  mosi_hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $fell(spi_sclk)) |-> $stable(spi_mosi));

  // R3
  mosi_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !spi_sclk && $past(!spi_sclk)) |-> $stable(spi_mosi));

  // R8
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $fell(spi_cs_n)) |-> (hi_cnt_q >= 16'(QUIET_CYC)));

  // R9
  no_start_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && !run) |=> spi_cs_n);
endmodule

bind spi_scan_master ssm_checker #(.QUIET_CYC(QUIET_CYC)) u_ssm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .res_valid(res_valid)
);

// File: tb/spi_scan_master_tb.sv
`timescale 1ns/1ps
module spi_scan_master_tb_top;
  localparam int DIV_HALF  = 5;
  localparam int QUIET_CYC = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [3:0]  ch_mask = 4'h0;
  logic        coding_sel = 1'b0;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        res_valid, res_err;
  logic [1:0]  res_tag;
  logic [11:0] res_data;

  spi_scan_master #(.DIV_HALF(DIV_HALF), .QUIET_CYC(QUIET_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ch_mask(ch_mask), .coding_sel(coding_sel),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data), .res_err(res_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] next_ch(input logic [1:0] last, input logic [3:0] m);
    for (int k = 1; k <= 4; k++) if (m[2'(last + 2'(k))]) return 2'(last + 2'(k));
    return last;
  endfunction

  // Model target plus monitor
  int          seg_frames = 0;
  logic [1:0]  bench_last = 2'd3;
  logic [1:0]  prev_req = 2'd0;
  logic [1:0]  slave_prev = 2'd0;
  logic [15:0] out_word = '0, rx_cmd = '0;
  int          bit_i = 0, t_edge = 0, t_csr = 0, frame_n = 0;
  bit          had_frame = 0;
  logic        prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        int r;
        logic [1:0] lead, tag;
        if (had_frame) chk(cyc - t_csr >= QUIET_CYC, "R8 quiet gap", cyc - t_csr, QUIET_CYC);
        chk(spi_sclk == 1'b1, "R1 sclk high at frame start", spi_sclk, 1);
        bit_i = 0; rx_cmd = '0; t_edge = cyc; frame_n++;
        r    = $urandom % 8;
        lead = (r == 0) ? 2'b01 : 2'b00;
        tag  = (r == 1) ? (slave_prev ^ 2'b01) : slave_prev;
        out_word = {lead, tag, 12'(frame_n * 149 + 7)};
      end
      if (!spi_cs_n && prev_sclk && !spi_sclk) begin
        chk(cyc - t_edge == DIV_HALF, "R2 phase before fall", cyc - t_edge, DIV_HALF);
        t_edge = cyc;
        rx_cmd = {rx_cmd[14:0], spi_mosi};
        if (bit_i < 16) spi_miso = out_word[15 - bit_i];
        bit_i++;
      end
      if (!spi_cs_n && !prev_sclk && spi_sclk) begin
        chk(cyc - t_edge == DIV_HALF, "R2 low phase", cyc - t_edge, DIV_HALF);
        t_edge = cyc;
      end
      if (!prev_cs && spi_cs_n) begin
        logic [11:0] cmd;
        logic [1:0]  e;
        logic        eerr;
        chk(bit_i == 16, "R1 falling edges per frame", bit_i, 16);
        chk(cyc - t_edge == DIV_HALF, "R2 final high phase", cyc - t_edge, DIV_HALF);
        cmd = rx_cmd[15:4];
        chk((cmd & 12'hF3E) == 12'h830 && rx_cmd[3:0] == 4'h0, "R3 fixed command bits",
            {cmd & 12'hF3E, rx_cmd[3:0]}, 16'h8300);
        chk(cmd[0] == coding_sel, "R3 coding bit", cmd[0], coding_sel);
        e = next_ch(bench_last, ch_mask);
        chk(cmd[7:6] == e, "R4 channel order", cmd[7:6], e);
        bench_last = e;
        if (seg_frames == 0) begin
          chk(res_valid == 1'b0, "R5 priming frame discarded", res_valid, 0);
        end else begin
          eerr = (out_word[15:14] != 2'b00) || (out_word[13:12] != prev_req);
          chk(res_valid == 1'b1, "R5 result per frame", res_valid, 1);
          chk(res_tag == out_word[13:12], "R6 tag", res_tag, out_word[13:12]);
          chk(res_data == out_word[11:0], "R6 data", res_data, out_word[11:0]);
          chk(res_err == eerr, "R7 error flag", res_err, eerr);
        end
        prev_req = cmd[7:6]; slave_prev = cmd[7:6];
        seg_frames++; t_csr = cyc; had_frame = 1;
      end else if (res_valid) begin
        chk(1'b0, "R5 stray result", 1, 0);
      end
      prev_cs = spi_cs_n; prev_sclk = spi_sclk;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    logic [3:0] directed [4];
    int fc;
    directed[0] = 4'b1111; directed[1] = 4'b0001;
    directed[2] = 4'b1010; directed[3] = 4'b1000;
    void'($urandom(32'h5EED));
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10 reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R10 reset sclk", spi_sclk, 1);
    chk(spi_mosi == 1'b0, "R10 reset mosi", spi_mosi, 0);
    chk(res_valid == 1'b0, "R10 reset valid", res_valid, 0);

    for (int s = 0; s < 8; s++) begin
      int nf;
      @(negedge clk);
      ch_mask    = (s < 4) ? directed[s] : 4'(($urandom % 15) + 1);
      coding_sel = (s < 2) ? s[0] : 1'($urandom % 2);
      seg_frames = 0; bench_last = 2'd3;
      run = 1'b1;
      nf = 5 + ($urandom % 6);
      wait (seg_frames >= nf);
      repeat ($urandom % 100) @(negedge clk);
      run = 1'b0;
      repeat (400) @(negedge clk);
      fc = frame_n;
      repeat (300) @(negedge clk);
      // R9: stopped scan starts nothing
      chk(frame_n == fc && spi_cs_n, "R9 no frame while stopped", frame_n, fc);
    end

    @(negedge clk);
    ch_mask = 4'h0; seg_frames = 0; bench_last = 2'd3;
    fc = frame_n;
    run = 1'b1;
    repeat (500) @(negedge clk);
    chk(frame_n == fc && spi_cs_n, "R9 empty mask starts nothing", frame_n, fc);
    run = 1'b0;
    repeat (10) @(negedge clk);
    summary();
  end
endmodule